// File: doc/BRIEF.md
# Blocked Carry-Lookahead Adder

This block adds two unsigned operands and a carry input. It produces the sum and a final carry output in the same cycle, with no registers. Each bit position first derives a generate term and a propagate term. The operand bits are split into equal groups. Inside a group, every carry is written out as a flat sum of products over that group's generate and propagate terms and the group's incoming carry. A carry therefore crosses a whole group through two logic levels instead of stepping from bit to bit.

The groups sit in a chain. Each group passes its outgoing carry to the next group as that group's incoming carry. The delay grows with the number of groups, not with the number of bits. The product terms stay bounded by the group size. Both the operand width and the group size are parameters.

Top module: `cla_adder_blocked`

## Requirements
- R1: `WIDTH` sets the operand width (default 32) and `GROUP_W` sets the group size (default 4); `GROUP_W` must divide `WIDTH` exactly.
- R2: A bit whose two operand bits are both 1 (generate, g = a AND b) always drives a carry of 1 into the next bit, whatever its own incoming carry is.
- R3: A bit whose two operand bits are both 0 (propagate p = a OR b equal to 0) always drives a carry of 0 into the next bit, whatever its own incoming carry is.
- R4: The carry into bit i+1 equals g_i OR (p_i AND c_i), where c_i is the carry into bit i.
- R5: Within a group, each carry is a two-level AND-OR function of only that group's g and p terms and the group's incoming carry.
- R6: The incoming carry of group 0 is the `cin` input. The incoming carry of each later group is the outgoing carry of the group below it. `cout` is the outgoing carry of the top group.
- R7: Sum bit i equals a_i XOR b_i XOR c_i.
- R8: For every input combination, the concatenation {cout, sum} equals a + b + cin, taken as a WIDTH+1 bit unsigned value. The outputs are purely combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
The bench builds three copies of the adder:
- 32 bits with groups of 4 (the defaults),
- 8 bits with groups of 4,
- 32 bits with groups of 8.

The 8-bit copy is small enough to drive with every pair of operands at both carry-in values. This covers every carry pattern across a group boundary and through the final carry output. The 32-bit copies receive directed operands that force a carry to travel the full chain, to stop at a killing bit, or to start at a generating bit. They also receive random operands. The second group size shows that the chaining and the flattened equations hold when a group is wider than the default.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Generate and propagate pair of one bit position.
    typedef struct packed {
        logic gen;
        logic prop;
    } bit_pg_t;

    function automatic int unsigned group_count(input int unsigned width, input int unsigned grp);
        return width / grp;
    endfunction

endpackage

// File: rtl/cla_pg_cell.sv
module cla_pg_cell #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] gen_v,
    output logic [WIDTH-1:0] prop_v
);
    import cla_pkg::*;

    bit_pg_t pg_d [WIDTH];

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            pg_d[i].gen  = op_a[i] & op_b[i];
            pg_d[i].prop = op_a[i] | op_b[i];
        end
        assign gen_v[i]  = pg_d[i].gen;
        assign prop_v[i] = pg_d[i].prop;
    end

endmodule

// File: rtl/cla_group.sv
module cla_group #(
    parameter int unsigned GROUP_W = 4
) (
    input  logic [GROUP_W-1:0] gen_v,
    input  logic [GROUP_W-1:0] prop_v,
    input  logic               grp_cin,
    output logic [GROUP_W-1:0] bit_carry,
    output logic               grp_cout
);
    logic [GROUP_W:0] carry_d;

    // Flattened sum of products: each carry is an OR of AND terms over this group only.
    always_comb begin
        carry_d[0] = grp_cin;
        for (int i = 0; i < GROUP_W; i++) begin
            logic acc;
            logic term;
            acc = 1'b0;
            for (int j = 0; j <= i; j++) begin
                term = gen_v[j];
                for (int k = j + 1; k <= i; k++) begin
                    term = term & prop_v[k];
                end
                acc = acc | term;
            end
            term = grp_cin;
            for (int k = 0; k <= i; k++) begin
                term = term & prop_v[k];
            end
            carry_d[i+1] = acc | term;
        end
    end

    assign bit_carry = carry_d[GROUP_W-1:0];
    assign grp_cout  = carry_d[GROUP_W];

    always_comb begin
        for (int i = 0; i < GROUP_W; i++) begin
            assert_generate_sets_R2: assert (!gen_v[i] || carry_d[i+1])
                else $error("generate bit %0d did not force carry", i);
            assert_kill_clears_R3: assert (prop_v[i] || !carry_d[i+1])
                else $error("non-propagating bit %0d passed a carry", i);
            assert_carry_recurrence_R4: assert (carry_d[i+1] == (gen_v[i] | (prop_v[i] & carry_d[i])))
                else $error("carry recurrence broken at bit %0d", i);
        end
    end

endmodule

// File: rtl/cla_sum.sv
module cla_sum #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] carry_in_v,
    output logic [WIDTH-1:0] sum_v
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        assign sum_v[i] = op_a[i] ^ op_b[i] ^ carry_in_v[i];
    end
endmodule

// File: rtl/cla_adder_blocked.sv
module cla_adder_blocked #(
    parameter int unsigned WIDTH   = 32,
    parameter int unsigned GROUP_W = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    import cla_pkg::*;

    localparam int unsigned NUM_GRP = group_count(WIDTH, GROUP_W);

    logic [WIDTH-1:0] gen_v;
    logic [WIDTH-1:0] prop_v;
    logic [WIDTH-1:0] carry_v;
    logic             chain_c [NUM_GRP+1];

    initial begin
        assert_group_divides_R1: assert (WIDTH % GROUP_W == 0 && GROUP_W > 0)
            else $error("GROUP_W must divide WIDTH");
    end

    cla_pg_cell #(.WIDTH(WIDTH)) pg_i (
        .op_a  (a),
        .op_b  (b),
        .gen_v (gen_v),
        .prop_v(prop_v)
    );

    assign chain_c[0] = cin;

    for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
        cla_group #(.GROUP_W(GROUP_W)) grp_i (
            .gen_v    (gen_v[k*GROUP_W +: GROUP_W]),
            .prop_v   (prop_v[k*GROUP_W +: GROUP_W]),
            .grp_cin  (chain_c[k]),
            .bit_carry(carry_v[k*GROUP_W +: GROUP_W]),
            .grp_cout (chain_c[k+1])
        );
    end

    assign cout = chain_c[NUM_GRP];

    cla_sum #(.WIDTH(WIDTH)) sum_i (
        .op_a      (a),
        .op_b      (b),
        .carry_in_v(carry_v),
        .sum_v     (sum)
    );

    always_comb begin
        assert_chain_entry_R6: assert (carry_v[0] == cin)
            else $error("group 0 carry-in differs from cin");
        assert_total_R8: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
            else $error("sum mismatch");
    end

endmodule

// File: tb/cla_adder_blocked_tb_top.sv
module cla_adder_blocked_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] a32, b32, s32;
    logic        c32, co32;
    logic [7:0]  a8, b8, s8;
    logic        c8, co8;
    logic [31:0] ag, bg, sg;
    logic        cg, cog;

    cla_adder_blocked #(.WIDTH(32), .GROUP_W(4)) dut_i (
        .a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));
    cla_adder_blocked #(.WIDTH(8), .GROUP_W(4)) dut8_i (
        .a(a8), .b(b8), .cin(c8), .sum(s8), .cout(co8));
    cla_adder_blocked #(.WIDTH(32), .GROUP_W(8)) dutg8_i (
        .a(ag), .b(bg), .cin(cg), .sum(sg), .cout(cog));

    task automatic chk32(input logic [31:0] x, input logic [31:0] y, input logic ci, input string tag);
        logic [32:0] exp;
        @(posedge clk);
        a32 = x; b32 = y; c32 = ci;
        @(negedge clk);
        exp = {1'b0, x} + {1'b0, y} + {32'd0, ci};
        checks++;
        if ({co32, s32} !== exp) begin
            errors++;
            $display("FAIL %s: a=%h b=%h cin=%b got %h expected %h", tag, x, y, ci, {co32, s32}, exp);
        end
    endtask

    task automatic test_zero_R8();
        chk32(32'd0, 32'd0, 1'b0, "R8 zero inputs");
    endtask

    task automatic test_full_chain_R6();
        chk32(32'hFFFF_FFFF, 32'd0, 1'b1, "R6 carry through all groups");
        chk32(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R6 R4 ripple all bits");
        chk32(32'h0000_000F, 32'h0000_0001, 1'b0, "R6 group boundary");
    endtask

    task automatic test_generate_R2();
        chk32(32'h8000_0000, 32'h8000_0000, 1'b0, "R2 top generate");
        chk32(32'h0001_0000, 32'h0001_0000, 1'b1, "R2 mid generate");
    endtask

    task automatic test_kill_R3();
        chk32(32'd0, 32'd0, 1'b1, "R3 cin stopped by zero bit");
        chk32(32'hFFFF_FF0F, 32'h0000_0000, 1'b1, "R3 kill inside group");
    endtask

    task automatic test_one_group_R5();
        chk32(32'h0000_0700, 32'h0000_0100, 1'b0, "R5 single group");
        chk32(32'h5555_5555, 32'hAAAA_AAAA, 1'b1, "R5 R7 alternating");
    endtask

    task automatic test_exhaustive8_R7();
        for (int ci = 0; ci < 2; ci++) begin
            for (int x = 0; x < 256; x++) begin
                for (int y = 0; y < 256; y++) begin
                    logic [8:0] exp;
                    @(posedge clk);
                    a8 = x[7:0]; b8 = y[7:0]; c8 = ci[0];
                    @(negedge clk);
                    exp = 9'(x + y + ci);
                    checks++;
                    if ({co8, s8} !== exp) begin
                        errors++;
                        $display("FAIL R7 R8 8-bit: a=%h b=%h cin=%0d got %h expected %h", x[7:0], y[7:0], ci, {co8, s8}, exp);
                    end
                end
            end
        end
    endtask

    task automatic test_random_R8();
        for (int n = 0; n < 2000; n++) begin
            chk32($urandom, $urandom, 1'($urandom), "R8 random");
        end
    endtask

    task automatic test_group8_R1();
        for (int n = 0; n < 1000; n++) begin
            logic [31:0] x, y;
            logic ci;
            logic [32:0] exp;
            x = (n == 0) ? 32'hFFFF_FFFF : $urandom;
            y = (n == 0) ? 32'd0 : $urandom;
            ci = (n == 0) ? 1'b1 : 1'($urandom);
            @(posedge clk);
            ag = x; bg = y; cg = ci;
            @(negedge clk);
            exp = {1'b0, x} + {1'b0, y} + {32'd0, ci};
            checks++;
            if ({cog, sg} !== exp) begin
                errors++;
                $display("FAIL R1 group of 8: a=%h b=%h cin=%b got %h expected %h", x, y, ci, {cog, sg}, exp);
            end
        end
    endtask

    initial begin
        a32 = '0; b32 = '0; c32 = 1'b0;
        a8 = '0; b8 = '0; c8 = 1'b0;
        ag = '0; bg = '0; cg = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        test_zero_R8();
        test_full_chain_R6();
        test_generate_R2();
        test_kill_R3();
        test_one_group_R5();
        test_exhaustive8_R7();
        test_random_R8();
        test_group8_R1();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule